// File: doc/BRIEF.md
# Pipelined Burst SRAM Without Bus Turnaround

This block is a cycle-accurate, synthesizable model of a synchronous static RAM with bursts. Reads and writes can follow each other on consecutive clocks with no idle cycle in between. Address, controls, chip selects and byte enables are captured on the rising clock edge. Read data comes back two enabled cycles after its address cycle. Write data is taken two enabled cycles after its address cycle. Because both use the same pipeline slot, the data path never needs a turnaround cycle.

A burst starts when the advance input is low and the chip is selected. Each later cycle with advance high steps a 2-bit counter through the four words of the aligned group. The step order is linear or interleaved, and a static input picks which. A clock-enable input freezes the whole block. Separate write-data and read-data ports, plus a read-valid flag, take the place of a shared bidirectional bus.

Top module: `pipe_burst_sram`

## Requirements
- R1: The chip is selected only when `sel1_n`=0, `sel2`=1 and `sel2_n`=0 in a cycle with `adv`=0. With `we_n`=1 and `oe_n`=0, such a cycle starts a read burst. The word at `addr` appears on `rdata` with `rvalid`=1 in the second enabled cycle after the address cycle. Any other chip-select combination with `adv`=0 is a deselect and yields no read data.
- R2: A selected cycle with `adv`=0 and `we_n`=0 starts a write burst. The `wdata` presented two enabled cycles after each write address cycle is stored at that cycle's address.
- R3: Byte b occupies bits [9b+8:9b] of a word and is written only when `bw_n[b]`=0 in that beat's address cycle. A write beat with `bw_n`=4'hF changes no memory.
- R4: With `order_ilv`=0, beat k (k = 0..3, wrapping) of a burst uses low address bits (s+k) mod 4, where s is the start address's low two bits. The upper address bits stay fixed for the whole burst.
- R5: With `order_ilv`=1, beat k uses low address bits s XOR k, and the upper address bits stay fixed.
- R6: A cycle with `adv`=1 continues the last burst's operation type. After a deselect, or after reset before any burst, such a cycle stays deselected.
- R7: While `clk_en_n`=1, all inputs are ignored. Outputs, the burst state and the pipeline hold their values, and memory is not written.
- R8: A read beat with `oe_n`=1 in its address cycle is a dummy read: the burst advances, `rvalid` stays 0 for that slot, and `rdata` is zero whenever `rvalid` is 0.
- R9: A read whose address cycle comes right after a write to the same address returns that write's enabled bytes, merged over the stored word.
- R10: Reset (`rst_n`=0, synchronous) empties the pipeline to the deselected state, clears `rvalid` and `rdata`, and leaves memory contents untouched.
- R11: Read and write beats may alternate on every cycle with no idle cycles, and every beat completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Suspend when high |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | Low: load new address; high: advance burst |
| we_n | input | 1 | Low: write burst, high: read burst |
| bw_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable for the read beat, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data, two enabled cycles after address |
| rdata | output | 36 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that `order_ilv` changes only while reset is held, and that every input is at a known level at each clock edge after reset. The bench meets both conditions. It switches burst order only inside a reset pulse. It drives every input from the falling edge, including during random traffic with suspend cycles and chip-select mistakes. The timing checks look only at pairs of consecutive enabled clocks, so a suspended cycle inside the window removes the obligation and never produces a false failure.

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram #(
  parameter int DEPTH  = 64,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel2_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic [BYTES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             order_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DW-1:0]    mem [DEPTH];
  op_t              b_op, s1_op, s2_op, cur_op;
  logic [AW-1:0]    b_base, s1_addr, s2_addr, cur_addr;
  logic [1:0]       b_cnt, nxt_cnt, off;
  logic [BYTES-1:0] s1_bw, s2_bw;
  logic             s1_oe_n, chosen, rd_now, fwd;
  logic [DW-1:0]    rd_word;

  assign chosen  = !sel1_n && sel2 && !sel2_n;
  assign nxt_cnt = b_cnt + 2'd1;
  assign off     = order_ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  assign rd_now  = (s1_op == OP_RD) && !s1_oe_n;
  assign fwd     = (s2_op == OP_WR) && (s2_addr == s1_addr);

  always_comb begin
    if (!adv) begin
      cur_addr = addr;
      cur_op   = !chosen ? OP_NONE : (we_n ? OP_RD : OP_WR);
    end else begin
      cur_addr = {b_base[AW-1:2], off};
      cur_op   = b_op;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign rd_word[b*BYTE_W +: BYTE_W] = (fwd && !s2_bw[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                            : mem[s1_addr][b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst_n && !clk_en_n && s2_op == OP_WR) begin
      for (int b = 0; b < BYTES; b++)
        if (!s2_bw[b]) mem[s2_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_op   <= OP_NONE;
      b_cnt  <= 2'd0;
      s1_op  <= OP_NONE;
      s2_op  <= OP_NONE;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (!clk_en_n) begin
      if (!adv) begin
        b_base <= addr;
        b_cnt  <= 2'd0;
        b_op   <= cur_op;
      end else begin
        b_cnt  <= nxt_cnt;
      end
      s1_op   <= cur_op;
      s1_addr <= cur_addr;
      s1_bw   <= bw_n;
      s1_oe_n <= oe_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      rvalid  <= rd_now;
      rdata   <= rd_now ? rd_word : '0;
    end
  end
endmodule

module pipe_burst_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel2_n,
  input logic          adv,
  input logic          we_n,
  input logic          oe_n,
  input logic          order_ilv,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  logic picked;
  assign picked = !sel1_n && sel2 && !sel2_n;

  a_r10_reset_clears: assert property (@(posedge clk) !rst_n |=> !rvalid);

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rvalid) && $stable(rdata)));

  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && picked && we_n && !oe_n) ##1 !clk_en_n |=> rvalid);

  a_r1_deselect_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && !picked) ##1 !clk_en_n |=> !rvalid);

  a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && picked && !we_n) ##1 !clk_en_n |=> !rvalid);

  a_r8_dummy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && oe_n) ##1 !clk_en_n |=> !rvalid);

  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  a_r4_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(order_ilv));
endmodule

bind pipe_burst_sram pipe_burst_sram_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel2_n(sel2_n), .adv(adv), .we_n(we_n), .oe_n(oe_n), .order_ilv(order_ilv),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/pipe_burst_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0;
  logic sel1_n = 1'b1, sel2 = 1'b1, sel2_n = 1'b0, adv = 1'b0, we_n = 1'b1;
  logic [3:0] bw_n = 4'h0;
  logic oe_n = 1'b0, order_ilv = 1'b0;
  logic [5:0] addr = '0;
  logic [35:0] wdata = '0, rdata;
  logic rvalid;

  always #4 clk = ~clk;

  pipe_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel2_n(sel2_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
    .order_ilv(order_ilv), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct { int op; int a; logic [3:0] bw; logic oe; } rec_t;
  rec_t pipe[$];
  logic [35:0] ref_mem [64];
  int m_op = 0, m_base = 0, m_cnt = 0;
  logic exp_rv = 1'b0;
  logic [35:0] exp_rq = '0;
  int n_tests = 0, n_fail = 0;
  string tag = "R10";

  task automatic model_edge();
    rec_t cur;
    int lo;
    if (!rst_n) begin
      pipe.delete(); m_op = 0; m_cnt = 0; exp_rv = 1'b0; exp_rq = '0;
      return;
    end
    if (clk_en_n) return;
    if (!adv) begin
      cur.a = addr;
      cur.op = (!sel1_n && sel2 && !sel2_n) ? (we_n ? 1 : 2) : 0;
      m_base = addr; m_cnt = 0; m_op = cur.op;
    end else begin
      m_cnt = (m_cnt + 1) % 4;
      lo = order_ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
      cur.a = (m_base / 4) * 4 + lo;
      cur.op = m_op;
    end
    cur.bw = bw_n; cur.oe = oe_n;
    if (pipe.size() == 2) begin
      if (pipe[0].op == 2)
        for (int b = 0; b < 4; b++)
          if (!pipe[0].bw[b]) ref_mem[pipe[0].a][b*9 +: 9] = wdata[b*9 +: 9];
      void'(pipe.pop_front());
    end
    exp_rv = 1'b0; exp_rq = '0;
    if (pipe.size() == 1 && pipe[0].op == 1 && !pipe[0].oe) begin
      exp_rv = 1'b1; exp_rq = ref_mem[pipe[0].a];
    end
    pipe.push_back(cur);
  endtask

  task automatic compare();
    n_tests++;
    if (rvalid !== exp_rv || rdata !== exp_rq) begin
      n_fail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, exp_rv, exp_rq);
    end
  endtask

  task automatic tick();
    wdata = 36'({$urandom(), $urandom()});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic start(input int a, input bit wr, input logic [3:0] bw, input bit oe);
    adv = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; sel2_n = 1'b0;
    addr = 6'(a); we_n = !wr; bw_n = bw; oe_n = oe; tick();
  endtask

  task automatic cont(input logic [3:0] bw, input bit oe);
    adv = 1'b1; bw_n = bw; oe_n = oe; tick();
  endtask

  task automatic desel(input int kind);
    adv = 1'b0; sel1_n = (kind == 0); sel2 = (kind != 1); sel2_n = (kind == 2); tick();
  endtask

  task automatic do_reset(input bit ilv);
    rst_n = 1'b0; tick(); order_ilv = ilv; tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R10"; do_reset(1'b0);
    desel(0); desel(0);

    tag = "R2";
    for (int k = 0; k < 16; k++) begin
      start(k * 4, 1, 4'h0, 0);
      for (int j = 0; j < 3; j++) cont(4'h0, 0);
    end
    desel(0); desel(0);

    tag = "R4";
    start(6, 0, 4'h0, 0); cont(4'h0, 0); cont(4'h0, 0); cont(4'h0, 0);
    start(13, 0, 4'h0, 0); for (int j = 0; j < 6; j++) cont(4'h0, 0);
    desel(1); desel(1);

    tag = "R11";
    for (int j = 0; j < 8; j++) begin
      start(20 + j, 1, 4'h0, 0);
      start(40 + j, 0, 4'h0, 0);
    end
    desel(2); desel(2);

    tag = "R9";
    start(5, 1, 4'h0, 0); start(5, 0, 4'h0, 0);
    start(7, 1, 4'b0101, 0); start(7, 0, 4'h0, 0);
    start(8, 1, 4'h0, 0); cont(4'b1100, 0); start(9, 0, 4'h0, 0);
    desel(0); desel(0);

    tag = "R3";
    start(10, 1, 4'hF, 0); start(11, 1, 4'b1010, 0); start(12, 1, 4'b0111, 0);
    desel(0); desel(0);
    start(10, 0, 4'h0, 0); start(11, 0, 4'h0, 0); start(12, 0, 4'h0, 0);
    desel(0); desel(0);

    tag = "R1";
    desel(0); desel(1); desel(2);
    start(30, 0, 4'h0, 0); desel(1); desel(0); desel(0);

    tag = "R6";
    desel(2); cont(4'h0, 0); cont(4'h0, 0); cont(4'h0, 0); desel(0); desel(0);

    tag = "R8";
    start(33, 0, 4'h0, 1); cont(4'h0, 0); cont(4'h0, 1); cont(4'h0, 0);
    desel(0); desel(0);

    tag = "R7";
    start(44, 0, 4'h0, 0); clk_en_n = 1'b1; adv = 1'b0; sel1_n = 1'b1; tick(); tick();
    clk_en_n = 1'b0; cont(4'h0, 0); clk_en_n = 1'b1; tick(); clk_en_n = 1'b0;
    cont(4'h0, 0); cont(4'h0, 0);
    start(50, 1, 4'h0, 0); clk_en_n = 1'b1; tick(); tick(); clk_en_n = 1'b0;
    desel(0); clk_en_n = 1'b1; tick(); clk_en_n = 1'b0; desel(0); desel(0);
    start(50, 0, 4'h0, 0); desel(0); desel(0);

    tag = "R5";
    do_reset(1'b1);
    tag = "R6"; cont(4'h0, 0); cont(4'h0, 0);
    tag = "R5";
    start(1, 0, 4'h0, 0); cont(4'h0, 0); cont(4'h0, 0); cont(4'h0, 0);
    start(23, 0, 4'h0, 0); for (int j = 0; j < 5; j++) cont(4'h0, 0);
    start(58, 1, 4'h0, 0); cont(4'h0, 0); cont(4'h0, 0); cont(4'h0, 0);
    start(56, 0, 4'h0, 0); for (int j = 0; j < 3; j++) cont(4'h0, 0);
    desel(0); desel(0);

    tag = "R10";
    start(3, 0, 4'h0, 0); cont(4'h0, 0); do_reset(1'b1); desel(0); desel(0);

    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      clk_en_n = ($urandom % 8) == 0;
      adv = $urandom % 2;
      if (!adv) begin
        int k;
        k = $urandom % 8;
        sel1_n = (k == 0); sel2 = (k != 1); sel2_n = (k == 2);
        we_n = $urandom % 2; addr = 6'($urandom);
      end
      bw_n = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      oe_n = ($urandom % 8) == 0;
      tick();
    end
    clk_en_n = 1'b0;
    desel(0); desel(0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule